// File: doc/BRIEF.md
# Master-slave multi-output PWM timer

The block makes a set of pulse-width-modulated outputs that share one period. A master down-counter sets the period and emits a one-cycle period pulse each time it wraps. Each slave channel holds a one-shot down-counter that the period pulse re-arms with that slave's duty value. The slave's output is active for as many count clocks as that duty value, beginning one count clock after the pulse. Every counter advances only on cycles where the shared count-clock enable is high.

One start input launches every channel in the same cycle. The launch loads all counters and emits a period pulse at once. One stop input halts every channel in the same cycle. The counters and output levels then freeze where they are. The period and duty values may change at any time, but each channel samples its value only at a period pulse, so a running period is never disturbed. Each output pin can be switched from the PWM level to a directly driven level through its enable bit.

Top module: `mspwm_timer`

## Requirements
- R1: While rst_ni is low, and on the first sample after its release, period_o, run_o, mst_cnt_o, every slv_cnt_o field and every PWM level are 0.
- R2: A start (start_i high with stop_i low) makes the very next sample show run_o all ones, period_o high for one cycle, mst_cnt_o equal to period_i and each slv_cnt_o field equal to its duty_i field.
- R3: While running, the master counts down by one on each cycle with cnt_en_i high and holds otherwise. On the enabled cycle where it is 0 it reloads period_i and pulses period_o, so pulses lie period_i + 1 enabled cycles apart.
- R4: For a duty value D not above period_i, the slave's PWM level is high for exactly D enabled cycles per period. It first goes high after the first enabled cycle that follows the period pulse, and it is low when the next pulse appears.
- R5: A duty value of 0 keeps the PWM level permanently low. A duty value above period_i keeps it permanently high from the second period on.
- R6: A change of period_i or duty_i during a period does not alter that period's length or widths. The new values govern only the periods that start at later pulses.
- R7: A stop (stop_i high) clears run_o on the next sample. After that, mst_cnt_o, slv_cnt_o and the PWM levels keep their values and period_o stays low until the next start.
- R8: When start_i and stop_i are high in the same cycle, the stop wins: run_o is 0 and no period pulse appears.
- R9: Where oe_i bit k is 0, pwm_o bit k follows lvl_i bit k. Where oe_i bit k is 1, pwm_o bit k follows the PWM level of slave k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Count-clock enable shared by all counters |
| start_i | input | 1 | Single-cycle start of all channels |
| stop_i | input | 1 | Single-cycle stop of all channels, wins over start |
| period_i | input | W | Master reload value (period minus one) |
| duty_i | input | N_SLV x W | Per-slave reload value (active width) |
| oe_i | input | N_SLV | Per-slave output enable: 1 selects PWM level |
| lvl_i | input | N_SLV | Per-slave level driven while the output enable is 0 |
| period_o | output | 1 | One-cycle period pulse |
| pwm_o | output | N_SLV | Output pins |
| run_o | output | N_SLV+1 | Per-channel running status, master in bit 0 |
| mst_cnt_o | output | W | Master counter value |
| slv_cnt_o | output | N_SLV x W | Slave counter values |

## Verification
A master counter that is off by one shows as a change in the spacing of period_o within the first full period, and as a wrong value on mst_cnt_o at the next sample. A slave counter that loads or decrements wrongly shows in the number of high samples on its pin within one period. The hold and stop-priority rules act on state that the counter outputs expose directly, so a stray update appears on mst_cnt_o or slv_cnt_o at the sample that follows it. A reload taken at the wrong moment shows in the period during which the value was changed, because that period's length or width then differs from the value it began with.

// File: rtl/mspwm_master.sv
module mspwm_master #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic [W-1:0] reload_i,
  output logic         run_o,
  output logic         tick_o,
  output logic         arm_o,
  output logic         pulse_o,
  output logic [W-1:0] cnt_o
);
  logic         run_q, pulse_q;
  logic [W-1:0] cnt_q;
  logic         start_acc, tick, wrap;

  assign start_acc = start_i & ~stop_i;
  assign tick      = run_q & cnt_en_i & ~stop_i;
  assign wrap      = tick & (cnt_q == '0);
  assign arm_o     = start_acc | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (stop_i)         run_q <= 1'b0;
      else if (start_i)   run_q <= 1'b1;
      pulse_q <= arm_o;
      if (arm_o)          cnt_q <= reload_i;
      else if (tick)      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign run_o   = run_q;
  assign tick_o  = tick;
  assign pulse_o = pulse_q;
  assign cnt_o   = cnt_q;

  p_pulse_running_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> run_q);
  p_start_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (run_q && pulse_q && cnt_q == $past(reload_i)));
  p_stop_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!run_q && !pulse_q));
  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/mspwm_slave.sv
module mspwm_slave #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         arm_i,
  input  logic         tick_i,
  input  logic [W-1:0] duty_i,
  output logic         lvl_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic         lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      if (arm_i)                        cnt_q <= duty_i;
      else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      // level lags the count by one count clock
      if (tick_i)                       lvl_q <= (cnt_q != '0);
    end
  end

  assign lvl_o = lvl_q;
  assign cnt_o = cnt_q;

  p_level_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(lvl_q));
  p_zero_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !arm_i) |=> (cnt_q == '0));
  p_zero_duty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !arm_i && tick_i) |=> !lvl_q);
endmodule

// File: rtl/mspwm_timer.sv
module mspwm_timer #(
  parameter int W     = 16,
  parameter int N_SLV = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cnt_en_i,
  input  logic                      start_i,
  input  logic                      stop_i,
  input  logic [W-1:0]              period_i,
  input  logic [N_SLV-1:0][W-1:0]   duty_i,
  input  logic [N_SLV-1:0]          oe_i,
  input  logic [N_SLV-1:0]          lvl_i,
  output logic                      period_o,
  output logic [N_SLV-1:0]          pwm_o,
  output logic [N_SLV:0]            run_o,
  output logic [W-1:0]              mst_cnt_o,
  output logic [N_SLV-1:0][W-1:0]   slv_cnt_o
);
  localparam int NCH = N_SLV + 1;

  logic             run, tick, arm;
  logic [N_SLV-1:0] slv_lvl;

  mspwm_master #(.W(W)) u_master (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_en_i (cnt_en_i),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .reload_i (period_i),
    .run_o    (run),
    .tick_o   (tick),
    .arm_o    (arm),
    .pulse_o  (period_o),
    .cnt_o    (mst_cnt_o)
  );

  for (genvar k = 0; k < N_SLV; k++) begin : g_slv
    mspwm_slave #(.W(W)) u_slave (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (arm),
      .tick_i (tick),
      .duty_i (duty_i[k]),
      .lvl_o  (slv_lvl[k]),
      .cnt_o  (slv_cnt_o[k])
    );
    assign pwm_o[k] = oe_i[k] ? slv_lvl[k] : lvl_i[k];
  end

  // all channels start and stop together
  assign run_o = {NCH{run}};

  p_run_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (run_o == {NCH{1'b1}}));
  p_no_pulse_stopped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !start_i) |=> !period_o);
endmodule

// File: tb/mspwm_timer_test.sv
`timescale 1ns/1ps
module mspwm_timer_test;
  localparam int W = 16;
  localparam int NV = 6;
  // period, duty0, duty1
  localparam int VEC [0:NV-1][0:2] = '{
    '{4, 2, 0}, '{3, 5, 3}, '{7, 1, 7}, '{1, 1, 2}, '{0, 0, 1}, '{6, 3, 6}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, stop = 1'b0;
  logic en_hold = 1'b0, en_div = 1'b0, phase = 1'b0;
  logic cnt_en;
  logic [W-1:0] period = '0;
  logic [1:0][W-1:0] duty = '0;
  logic [1:0] oe = 2'b11, lvl = 2'b00;
  logic period_o;
  logic [1:0] pwm;
  logic [2:0] run;
  logic [W-1:0] mcnt;
  logic [1:0][W-1:0] scnt;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  always @(negedge clk) phase <= ~phase;
  assign cnt_en = en_hold ? 1'b0 : (en_div ? phase : 1'b1);

  mspwm_timer #(.W(W), .N_SLV(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_en_i(cnt_en), .start_i(start), .stop_i(stop),
    .period_i(period), .duty_i(duty), .oe_i(oe), .lvl_i(lvl),
    .period_o(period_o), .pwm_o(pwm), .run_o(run), .mst_cnt_o(mcnt), .slv_cnt_o(scnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 300 && !period_o; i++) @(negedge clk);
  endtask

  // counts samples from the current pulse up to the next one
  task automatic meas(output int per, output int h0, output int h1);
    per = 0; h0 = 0; h1 = 0;
    do begin
      h0 += int'(pwm[0]); h1 += int'(pwm[1]); per++;
      @(negedge clk);
    end while (!period_o && per < 300);
  endtask

  function automatic int exp_hi(int d, int p);
    return (d > p) ? p + 1 : d;
  endfunction

  task automatic do_stop_check();
    logic [W-1:0] m0;
    logic [1:0][W-1:0] s0;
    logic [1:0] p0;
    int pulses;
    m0 = mcnt; s0 = scnt; p0 = pwm;
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(run == 3'b000, "R7 run cleared", int'(run), 0);
    pulses = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      pulses += int'(period_o);
    end
    chk(mcnt == m0, "R7 master held", int'(mcnt), int'(m0));
    chk(scnt == s0, "R7 slaves held", int'(scnt), int'(s0));
    chk(pwm == p0, "R7 levels held", int'(pwm), int'(p0));
    chk(pulses == 0, "R7 no pulse", pulses, 0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog R3 actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int per, h0, h1;
    repeat (3) @(negedge clk);
    chk(period_o == 0 && run == 0 && mcnt == 0 && scnt == 0 && pwm == 0,
        "R1 in reset", int'(run), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(period_o == 0 && run == 0 && mcnt == 0 && scnt == 0 && pwm == 0,
        "R1 after release", int'(mcnt), 0);

    // R8: simultaneous start and stop
    period = 16'd3;
    start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    chk(run == 3'b000, "R8 run stays low", int'(run), 0);
    chk(period_o == 1'b0, "R8 no pulse", int'(period_o), 0);

    for (int v = 0; v < NV; v++) begin
      period  = W'(VEC[v][0]);
      duty[0] = W'(VEC[v][1]);
      duty[1] = W'(VEC[v][2]);
      do_start();
      chk(run == 3'b111 && period_o, "R2 start status", int'(run), 7);
      chk(mcnt == period, "R2 master load", int'(mcnt), int'(period));
      chk(scnt == duty, "R2 slave load", int'(scnt), int'(duty));
      meas(per, h0, h1);
      for (int k = 0; k < 2; k++) begin
        meas(per, h0, h1);
        chk(per == VEC[v][0] + 1, "R3 period length", per, VEC[v][0] + 1);
        chk(h0 == exp_hi(VEC[v][1], VEC[v][0]),
            (VEC[v][1] == 0 || VEC[v][1] > VEC[v][0]) ? "R5 width s0" : "R4 width s0",
            h0, exp_hi(VEC[v][1], VEC[v][0]));
        chk(h1 == exp_hi(VEC[v][2], VEC[v][0]),
            (VEC[v][2] == 0 || VEC[v][2] > VEC[v][0]) ? "R5 width s1" : "R4 width s1",
            h1, exp_hi(VEC[v][2], VEC[v][0]));
      end
      do_stop_check();
    end

    // R3: enable gating
    period = 16'd3; duty[0] = 16'd2; duty[1] = 16'd5;
    do_start();
    en_hold = 1'b1;
    begin
      logic [W-1:0] m0;
      int pulses;
      m0 = mcnt; pulses = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        pulses += int'(period_o);
      end
      chk(mcnt == m0 && pulses == 0, "R3 hold without enable", int'(mcnt), int'(m0));
    end
    en_hold = 1'b0; en_div = 1'b1;
    wait_pulse();
    meas(per, h0, h1);
    meas(per, h0, h1);
    chk(per == 8, "R3 half-rate period", per, 8);
    chk(h0 == 4, "R4 half-rate width", h0, 4);
    chk(h1 == 8, "R5 half-rate full duty", h1, 8);
    en_div = 1'b0;
    do_stop_check();

    // R6: reload change mid-period
    period = 16'd5; duty[0] = 16'd2; duty[1] = 16'd0;
    do_start();
    meas(per, h0, h1);
    period = 16'd3; duty[0] = 16'd3;
    chk(mcnt == 16'd5, "R6 master keeps old reload", int'(mcnt), 5);
    meas(per, h0, h1);
    chk(per == 6, "R6 current period unchanged", per, 6);
    chk(h0 == 2, "R6 current width unchanged", h0, 2);
    meas(per, h0, h1);
    chk(per == 4, "R6 new period applied", per, 4);
    chk(h0 == 3, "R6 new width applied", h0, 3);

    // R9: manual levels
    oe = 2'b00; lvl = 2'b01;
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (pwm != lvl) bad++;
      end
      chk(bad == 0, "R9 manual level 01", bad, 0);
      lvl = 2'b10; bad = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (pwm != lvl) bad++;
      end
      chk(bad == 0, "R9 manual level 10", bad, 0);
    end
    oe = 2'b11;
    wait_pulse();
    meas(per, h0, h1);
    chk(h0 == 3, "R9 enable restores PWM", h0, 3);
    do_stop_check();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule